// File: doc/BRIEF.md
# Quartile-Level Synchronous FIFO

This block is a single-clock first-in first-out buffer for 32-bit words. It sits between a memory arbiter and a video stream client so the two sides can move data at different rates. A writer pushes one word per cycle with a write enable. A reader pulls one word per cycle with a read enable, and the word appears on a registered output in the following cycle.

Besides full and empty flags, the buffer reports its occupancy as a coarse 2-bit quartile code. Client logic uses this code to decide when a whole burst can be requested without overflowing or underflowing the buffer. A synchronous initialise input empties the buffer at any time. The depth is a power of two of at least 32 words, so every quartile holds a whole number of 8-word bursts.

Top module: `quart_fifo`

## Requirements
- R1: Words are 32 bits wide. A word presented with `push` high while the buffer is not full is stored at that rising edge, and words leave in the order they were stored.
- R2: When `pop` is high at a rising edge and the buffer is not empty, the oldest word appears on `pop_data` after that edge. At every other edge `pop_data` keeps its value.
- R3: `flush` high at a rising edge empties the buffer at that edge and overrides any `push` or `pop` in the same cycle. `pop_data` keeps its value.
- R4: With `rst_n` low at a rising edge the block clears synchronously: `is_empty`=1, `is_full`=0, `level`=00, `pop_data`=0.
- R5: `level` equals occupancy divided by DEPTH/4, saturated at 11. With DEPTH=64 this gives 0–15 words → 00, 16–31 → 01, 32–47 → 10, and 48–64 → 11.
- R6: `is_full` is 1 exactly when DEPTH words are held, and `is_empty` is 1 exactly when none are held. Both flags change at the same edge as the occupancy.
- R7: A `push` while full is ignored. The stored words, their order and the flags stay unchanged.
- R8: A `pop` while empty is ignored. `pop_data` and the flags stay unchanged.
- R9: `push` and `pop` together, while neither full nor empty, store one word and deliver one word, and the occupancy and `level` stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Synchronous initialise; empties the buffer |
| push | input | 1 | Write enable |
| push_data | input | 32 | Word to store |
| pop | input | 1 | Read enable |
| pop_data | output | 32 | Registered read word, valid the cycle after `pop` |
| is_full | output | 1 | Buffer holds DEPTH words |
| is_empty | output | 1 | Buffer holds no words |
| level | output | 2 | Occupancy quartile code |

## Verification
The assertions do not assume that clients respect the flags. They expect that `push` at full and `pop` at empty may occur, and they require the design to absorb both without any change of state. Apart from reset, they assume only that `flush` is a clean synchronous level. The random stimulus changes its push and pop bias across phases, so the buffer reaches both full and empty many times while the opposite request is still being issued. The directed cases walk the occupancy across each quartile boundary. They also assert `flush` together with `push` and `pop`.

// File: rtl/qf_pkg.sv
// Package qf_pkg: shared types for the quartile-level FIFO.
// Assumes nothing beyond a 2-bit level code.
package qf_pkg;
    typedef enum logic [1:0] {
        LVL_Q0 = 2'b00,
        LVL_Q1 = 2'b01,
        LVL_Q2 = 2'b10,
        LVL_Q3 = 2'b11
    } level_t;
endpackage

// File: rtl/qf_ptr_ctrl.sv
// qf_ptr_ctrl: read/write pointers, occupancy count and registered flags.
// Gates requests against the flags so that a push at full or a pop at empty has
// no effect. Assumes DEPTH is a power of two.
module qf_ptr_ctrl #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic              pop,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [CNT_W-1:0] count_nxt;

    // Qualify requests with the current flags.
    always_comb begin
        wr_ok = push && !full && !flush;
        rd_ok = pop && !empty && !flush;
    end

    // Next occupancy from the accepted requests.
    always_comb begin
        count_nxt = count;
        if (flush)
            count_nxt = '0;
        else if (wr_ok && !rd_ok)
            count_nxt = count + 1'b1;
        else if (rd_ok && !wr_ok)
            count_nxt = count - 1'b1;
    end

    // Pointer, count and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_addr <= '0;
            rd_addr <= '0;
            count   <= '0;
            full    <= 1'b0;
            empty   <= 1'b1;
        end else begin
            if (wr_ok) wr_addr <= wr_addr + 1'b1;
            if (rd_ok) rd_addr <= rd_addr + 1'b1;
            count <= count_nxt;
            full  <= (count_nxt == CNT_MAX);
            empty <= (count_nxt == '0);
        end
    end

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (full && $stable(count) && $stable(wr_addr))); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> (empty && $stable(rd_addr))); // R8
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !full && count == '0)); // R3
    AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty && !flush) |=> $stable(count)); // R9
endmodule

// File: rtl/qf_store.sv
// qf_store: word storage with a registered read port.
// Writes land on the clock edge; read data is loaded only on an accepted pop
// and held otherwise. Assumes the addresses come from qf_ptr_ctrl.
module qf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [DATA_W-1:0] wd,
    input  logic              re,
    input  logic [ADDR_W-1:0] ra,
    output logic [DATA_W-1:0] rd
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Storage array write.
    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
    end

    // Registered read word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd <= '0;
        else if (re)
            rd <= mem[ra];
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rd)); // R2
endmodule

// File: rtl/qf_level.sv
// qf_level: maps the occupancy count to a 2-bit quartile code, saturated at
// the top quartile when the buffer is full. Assumes DEPTH >= 4, a power of two.
module qf_level
    import qf_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             full,
    input  logic             empty,
    output level_t           level
);
    // Top two bits of the in-range count, or the top code when count == DEPTH.
    always_comb begin
        if (count[ADDR_W])
            level = LVL_Q3;
        else
            level = level_t'(count[ADDR_W-1:ADDR_W-2]);
    end

    AST_LEVEL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (level == LVL_Q3)); // R5
    AST_LEVEL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (level == LVL_Q0)); // R5
endmodule

// File: rtl/quart_fifo.sv
// quart_fifo: single-clock 32-bit FIFO with full/empty flags and a quartile
// level code. The read data is registered. flush empties the buffer.
// Assumes DEPTH is a power of two of at least 32 words.
module quart_fifo
    import qf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              is_full,
    output logic              is_empty,
    output logic [1:0]        level
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;

    logic              wr_ok, rd_ok;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [CNT_W-1:0]  count;
    level_t            lvl;

    qf_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .count(count), .full(is_full), .empty(is_empty)
    );

    qf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(wr_ok), .wa(wr_addr), .wd(push_data),
        .re(rd_ok), .ra(rd_addr), .rd(pop_data)
    );

    qf_level #(.DEPTH(DEPTH)) u_lvl (
        .clk(clk), .rst_n(rst_n), .count(count), .full(is_full),
        .empty(is_empty), .level(lvl)
    );

    // Present the enum as a plain vector at the boundary.
    always_comb level = lvl;
endmodule

// File: tb/sim_quart_fifo.sv
`timescale 1ns/1ps
module sim_quart_fifo;
    localparam int D = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0, push = 1'b0, pop = 1'b0;
    logic [31:0] push_data = '0;
    logic [31:0] pop_data;
    logic        is_full, is_empty;
    logic [1:0]  level;

    int          n_chk = 0, n_bad = 0;
    logic [31:0] mq[$];
    logic [31:0] exp_rd = '0;

    always #2.5 clk = ~clk;

    quart_fifo u0 (.clk(clk), .rst_n(rst_n), .flush(flush), .push(push),
        .push_data(push_data), .pop(pop), .pop_data(pop_data),
        .is_full(is_full), .is_empty(is_empty), .level(level));

    function automatic logic [1:0] exp_level(int n);
        if (n >= D) return 2'b11;
        return 2'(n / (D / 4));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare all outputs against the model.
    task automatic chk_all(string tag);
        chk({tag, " pop_data"}, pop_data, exp_rd);
        chk({tag, " is_full"}, 32'(is_full), 32'(mq.size() == D));
        chk({tag, " is_empty"}, 32'(is_empty), 32'(mq.size() == 0));
        chk({tag, " level"}, 32'(level), 32'(exp_level(mq.size())));
    endtask

    // One cycle: drive at negedge, update the model at the edge, check after.
    task automatic step(logic f, logic w, logic [31:0] wd, logic r, string tag);
        bit fl, em;
        flush = f; push = w; push_data = wd; pop = r;
        fl = (mq.size() == D); em = (mq.size() == 0);
        @(posedge clk);
        #0.5;
        if (f) mq.delete();
        else begin
            if (r && !em) exp_rd = mq.pop_front();
            if (w && !fl) mq.push_back(wd);
        end
        @(negedge clk);
        flush = 0; push = 0; pop = 0;
        chk_all(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R4 reset");

        // R8: pop while empty is ignored
        step(0, 0, 0, 1, "R8 pop empty");
        // R1/R2 ordering, R5 quartile boundaries
        for (int i = 0; i < D; i++) begin
            step(0, 1, 32'hA000_0000 + 32'(i), 0, "R5 R6 fill");
        end
        // R7: push while full is ignored
        step(0, 1, 32'hDEAD_BEEF, 0, "R7 push full");
        step(0, 1, 32'hDEAD_BEEF, 0, "R7 push full again");
        // drain and check order (R1, R2)
        for (int i = 0; i < D; i++) step(0, 0, 0, 1, "R1 R2 drain");
        step(0, 0, 0, 0, "R2 hold");
        step(0, 0, 0, 1, "R8 pop empty after drain");
        // push+pop at empty: only the push takes effect
        step(0, 1, 32'h1111_0001, 1, "R8 push pop empty");
        step(0, 1, 32'h1111_0002, 0, "R1 push");
        // R9 simultaneous while partly filled
        for (int i = 0; i < 20; i++) step(0, 1, 32'h2222_0000 + 32'(i), 1, "R9 both");
        // R3: flush with push and pop in the same cycle
        for (int i = 0; i < 20; i++) step(0, 1, 32'h3333_0000 + 32'(i), 0, "R5 refill");
        step(1, 1, 32'h4444_4444, 1, "R3 flush");
        step(0, 0, 0, 1, "R3 R8 pop after flush");
        step(0, 1, 32'h5555_5555, 0, "R3 push after flush");
        step(0, 0, 0, 1, "R3 R1 read after flush");
        // random phases with varying bias
        for (int ph = 0; ph < 12; ph++) begin
            int wp, rp;
            wp = (ph % 3 == 0) ? 85 : (ph % 3 == 1) ? 20 : 50;
            rp = (ph % 3 == 0) ? 20 : (ph % 3 == 1) ? 85 : 50;
            for (int c = 0; c < 300; c++) begin
                logic w, r, f;
                w = ($urandom_range(99) < wp);
                r = ($urandom_range(99) < rp);
                f = ($urandom_range(999) == 0);
                step(f, w, $urandom, r, "R1 R5 R7 R8 R9 random");
            end
        end
        // R4: reset clears mid-stream
        step(0, 1, 32'h6666_6666, 0, "R1 pre-reset");
        step(0, 0, 0, 1, "R2 pre-reset read");
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mq.delete(); exp_rd = '0;
        chk_all("R4 reset mid-run");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule